// File: doc/BRIEF.md
# Register-Programmed Clock Rate Divider

This block divides a single parent clock by a divisor held in a bit field of a memory-mapped control register. The parent clock is seen as the system clock `clk`, qualified by an enable `step_in`. The divider counts only the enabled cycles. A write port loads the register. The field's code is turned into a divisor by one of four encodings, chosen by a parameter:

- code plus one,
- code used directly,
- two to the power of the code,
- a lookup table in which a zero entry marks a forbidden code.

For the first three encodings, the divisor must also lie inside a minimum and a maximum set by parameters.

The block has two outputs from the same counter. `div_tick` is a one-cycle clock-enable at the start of each output period. `div_clk` is a level-shaped divided clock that is never gated. A write that decodes to a forbidden divisor is dropped as a whole, and `wr_err` pulses. The same register holds an autoidle bit, whose polarity a parameter can invert, and this bit is exported as `autoidle_en`.

A change of divisor is held back until the current output period ends. This control lives in a two-state machine:

- `ST_RUN` means no change is waiting. It goes to `ST_PEND` when an accepted write delivers a new divisor.
- `ST_PEND` holds the waiting divisor. At the last enabled step of the period it loads that divisor and returns to `ST_RUN`. If another accepted write arrives in that same cycle, it stays in `ST_PEND` and holds the newer value instead.

Top module: `clk_rate_div`

## Requirements
- R1: In code-plus-one encoding (the default), field code c gives divisor c+1; with defaults (field at bits 10:8, maximum 6), codes 0 to 5 are accepted and give divisors 1 to 6.
- R2: In direct encoding, code c gives divisor c, and code 0 is rejected.
- R3: In power-of-two encoding, code c gives divisor 2^c, subject to the maximum.
- R4: In table encoding, code c selects the 8-bit entry at bits 8c+7:8c of the table parameter; a zero entry makes code c rejected.
- R5: `rd_data` returns the last accepted divisor code at bits FIELD_SHIFT+FIELD_W-1:FIELD_SHIFT and the autoidle bit at bit AIDLE_SHIFT; every other bit reads zero.
- R6: Outside table encoding, a divisor below MIN_DIV or above MAX_DIV is rejected.
- R7: A rejected write leaves the register and the active divisor unchanged, and `wr_err` is high for exactly the one cycle after the write.
- R8: A new divisor takes effect only when the current period has run all of its steps, so the period in which the write lands keeps its old length.
- R9: For divisor N>1, `div_clk` is high for the first floor(N/2) steps of each period and low for the rest.
- R10: With divisor 1, both `div_clk` and `div_tick` equal `step_in`.
- R11: With AIDLE_INV=1 (the default), `autoidle_en` is the inverse of the stored autoidle bit, so writing 0 enables autoidle.
- R12: After reset, the register holds RST_CODE in its field and 0 in its autoidle bit, the divisor is the decode of RST_CODE, and `wr_err` is low.
- R13: Only cycles with `step_in` high advance the divider, and `div_tick` occurs only in such a cycle; one period of divisor N spans N enabled steps.

Example: with defaults, a write whose field holds code 4 selects divisor 5. With `step_in` held high, `div_tick` then pulses every 5 cycles, and `div_clk` is high for 2 of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write value |
| step_in | input | 1 | Parent clock enable; one step per high cycle |
| rd_data | output | REG_W | Register readback |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| div_tick | output | 1 | Clock-enable pulse at the start of each period |
| div_clk | output | 1 | Divided clock level |
| autoidle_en | output | 1 | Autoidle enable after the polarity setting |

## Verification
The hardest situation to reach is a write that lands in the middle of a long period. The bench must show that the old period finishes at full length and only the next period uses the new divisor. To get there, the bench syncs to a tick at divisor 6, waits two cycles, and writes divisor 2. It then checks that the interval from that tick is still 6 cycles and that the following interval is 2.

Three more situations need care:
- **Encodings.** Bench copies of the block in the other three encodings take the same write stream, so each code is accepted or rejected under all four encodings at once.
- **Step gating.** A toggling `step_in` shows that periods count enabled steps, not cycles.
- **Divide-by-one.** An irregular `step_in` pattern exercises the pass-through at divisor 1.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ENC_PLUS_ONE,
        ENC_DIRECT,
        ENC_POW2,
        ENC_TABLE
    } enc_mode_e;

    typedef enum logic {
        ST_RUN,
        ST_PEND
    } core_st_e;

    typedef struct packed {
        logic        ok;
        logic [31:0] dv;
    } dec_t;

endpackage

// File: rtl/crd_ctrl_reg.sv
module crd_ctrl_reg
    import clkdiv_pkg::*;
#(
    parameter int                      REG_W       = 32,
    parameter int                      FIELD_SHIFT = 8,
    parameter int                      FIELD_W     = 3,
    parameter enc_mode_e               MODE        = ENC_PLUS_ONE,
    parameter int                      MIN_DIV     = 1,
    parameter int                      MAX_DIV     = 6,
    parameter int                      AIDLE_SHIFT = 0,
    parameter int                      RST_CODE    = 0,
    parameter logic [(8<<FIELD_W)-1:0] DIV_TABLE   = '0,
    parameter int                      DIV_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             wr_err,
    output logic             new_valid,
    output logic [DIV_W-1:0] new_div,
    output logic [DIV_W-1:0] init_div,
    output logic             aidle_bit
);

    function automatic dec_t decode(input logic [FIELD_W-1:0] c);
        dec_t r;
        case (MODE)
            ENC_PLUS_ONE: r.dv = 32'(c) + 32'd1;
            ENC_DIRECT:   r.dv = 32'(c);
            ENC_POW2:     r.dv = 32'd1 << c;
            default:      r.dv = 32'(DIV_TABLE[{c, 3'b000} +: 8]);
        endcase
        if (MODE == ENC_TABLE)
            r.ok = (r.dv != 0) && (r.dv <= 32'(MAX_DIV));
        else
            r.ok = (r.dv != 0) && (r.dv >= 32'(MIN_DIV)) && (r.dv <= 32'(MAX_DIV));
        return r;
    endfunction

    localparam dec_t RST_DEC = decode(FIELD_W'(RST_CODE));

    logic [FIELD_W-1:0] code_q;
    logic               aid_q;
    logic               err_q;
    logic               nv_q;
    logic [DIV_W-1:0]   nd_q;
    logic [FIELD_W-1:0] wr_code;
    dec_t               wr_dec;

    assign wr_code = wr_data[FIELD_SHIFT +: FIELD_W];
    assign wr_dec  = decode(wr_code);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= FIELD_W'(RST_CODE);
            aid_q  <= 1'b0;
            err_q  <= 1'b0;
            nv_q   <= 1'b0;
            nd_q   <= DIV_W'(RST_DEC.dv);
        end else begin
            err_q <= 1'b0;
            nv_q  <= 1'b0;
            if (wr_en) begin
                if (wr_dec.ok) begin
                    code_q <= wr_code;
                    aid_q  <= wr_data[AIDLE_SHIFT];
                    nd_q   <= DIV_W'(wr_dec.dv);
                    nv_q   <= 1'b1;
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    assign rd_data   = (REG_W'(code_q) << FIELD_SHIFT) | (REG_W'(aid_q) << AIDLE_SHIFT);
    assign wr_err    = err_q;
    assign new_valid = nv_q;
    assign new_div   = nd_q;
    assign init_div  = DIV_W'(RST_DEC.dv);
    assign aidle_bit = aid_q;

endmodule

// File: rtl/crd_divcore.sv
module crd_divcore
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_in,
    input  logic             new_valid,
    input  logic [DIV_W-1:0] new_div,
    input  logic [DIV_W-1:0] init_div,
    output logic             tick,
    output logic             lvl,
    output logic [DIV_W-1:0] cur_div,
    output logic [DIV_W-1:0] phase
);

    core_st_e         st_q, st_d;
    logic [DIV_W-1:0] cur_q, cnt_q, pend_q;
    logic             period_end;

    assign period_end = step_in && (cnt_q == cur_q - DIV_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (new_valid) st_d = ST_PEND;
            ST_PEND: if (period_end && !new_valid) st_d = ST_RUN;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= init_div;
            cnt_q  <= '0;
            pend_q <= init_div;
        end else begin
            if (period_end) begin
                cnt_q <= '0;
                if (st_q == ST_PEND) cur_q <= pend_q;
            end else if (step_in) begin
                cnt_q <= cnt_q + DIV_W'(1);
            end
            if (new_valid) pend_q <= new_div;
        end
    end

    // outputs
    always_comb begin
        tick = step_in && (cnt_q == '0);
        if (cur_q == DIV_W'(1)) lvl = step_in;
        else                    lvl = (cnt_q < (cur_q >> 1));
    end

    assign cur_div = cur_q;
    assign phase   = cnt_q;

endmodule

// File: rtl/clk_rate_div.sv
module clk_rate_div
    import clkdiv_pkg::*;
#(
    parameter int                      REG_W       = 32,
    parameter int                      FIELD_SHIFT = 8,
    parameter int                      FIELD_W     = 3,
    parameter enc_mode_e               MODE        = ENC_PLUS_ONE,
    parameter int                      MIN_DIV     = 1,
    parameter int                      MAX_DIV     = 6,
    parameter int                      AIDLE_SHIFT = 0,
    parameter bit                      AIDLE_INV   = 1'b1,
    parameter int                      RST_CODE    = 0,
    parameter logic [(8<<FIELD_W)-1:0] DIV_TABLE   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             step_in,
    output logic [REG_W-1:0] rd_data,
    output logic             wr_err,
    output logic             div_tick,
    output logic             div_clk,
    output logic             autoidle_en
);

    localparam int DIV_W = $clog2(MAX_DIV + 1);

    logic             new_valid;
    logic [DIV_W-1:0] new_div, init_div, cur_div, phase;
    logic             aidle_bit;

    crd_ctrl_reg #(
        .REG_W(REG_W), .FIELD_SHIFT(FIELD_SHIFT), .FIELD_W(FIELD_W),
        .MODE(MODE), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
        .AIDLE_SHIFT(AIDLE_SHIFT), .RST_CODE(RST_CODE),
        .DIV_TABLE(DIV_TABLE), .DIV_W(DIV_W)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wr_err(wr_err), .new_valid(new_valid),
        .new_div(new_div), .init_div(init_div), .aidle_bit(aidle_bit)
    );

    crd_divcore #(.DIV_W(DIV_W)) u_core (
        .clk(clk), .rst_n(rst_n), .step_in(step_in),
        .new_valid(new_valid), .new_div(new_div), .init_div(init_div),
        .tick(div_tick), .lvl(div_clk), .cur_div(cur_div), .phase(phase)
    );

    generate
        if (AIDLE_INV) begin : g_aid_inv
            assign autoidle_en = ~aidle_bit;
        end else begin : g_aid_dir
            assign autoidle_en = aidle_bit;
        end
    endgenerate

endmodule

// File: rtl/clk_rate_div_chk.sv
module clk_rate_div_chk #(
    parameter int REG_W = 32,
    parameter int DIV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_err,
    input logic [REG_W-1:0] rd_data,
    input logic             step_in,
    input logic             div_tick,
    input logic             div_clk,
    input logic [DIV_W-1:0] cur_div,
    input logic [DIV_W-1:0] phase
);

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en)); // R7

    AST_REJECT_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $stable(rd_data)); // R7

    AST_REG_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(rd_data)); // R5

    AST_TICK_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |-> step_in); // R13

    AST_DIV_SWAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_div != $past(cur_div)) |-> (phase == '0)); // R8

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase < cur_div); // R9

    AST_DIV1_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_div == DIV_W'(1)) |-> (div_clk == step_in)); // R10

endmodule

bind clk_rate_div clk_rate_div_chk #(.REG_W(REG_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_err(wr_err),
    .rd_data(rd_data), .step_in(step_in), .div_tick(div_tick),
    .div_clk(div_clk), .cur_div(cur_div), .phase(phase)
);

// File: tb/clk_rate_div_test.sv
`timescale 1ns/1ps
module clk_rate_div_test;
    import clkdiv_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        step_in = 1'b1;
    int          step_mode = 0;
    int          cyc = 0;

    logic [31:0] rd [4];
    logic [3:0]  err;
    logic        tick, dclk, aen;
    logic [2:0]  tick_o, dclk_o, aen_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        case (step_mode)
            0:       step_in <= 1'b1;
            1:       step_in <= ~step_in;
            default: step_in <= (cyc % 3) != 0;
        endcase
    end

    clk_rate_div uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .step_in(step_in),
        .rd_data(rd[0]), .wr_err(err[0]), .div_tick(tick), .div_clk(dclk), .autoidle_en(aen));

    clk_rate_div #(.MODE(ENC_DIRECT), .RST_CODE(1)) uut_dir (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .step_in(step_in),
        .rd_data(rd[1]), .wr_err(err[1]), .div_tick(tick_o[0]), .div_clk(dclk_o[0]),
        .autoidle_en(aen_o[0]));

    clk_rate_div #(.MODE(ENC_POW2), .MAX_DIV(8)) uut_p2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .step_in(step_in),
        .rd_data(rd[2]), .wr_err(err[2]), .div_tick(tick_o[1]), .div_clk(dclk_o[1]),
        .autoidle_en(aen_o[1]));

    clk_rate_div #(.MODE(ENC_TABLE), .MAX_DIV(16),
                   .DIV_TABLE(64'h03_02_00_00_10_00_08_04)) uut_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .step_in(step_in),
        .rd_data(rd[3]), .wr_err(err[3]), .div_tick(tick_o[2]), .div_clk(dclk_o[2]),
        .autoidle_en(aen_o[2]));

    // vectors: code, expected err {tbl,p2,dir,plus1}, expected plus-one divisor
    localparam int      NV = 8;
    localparam int      VEC_CODE [NV] = '{1, 4, 6, 0, 2, 7, 5, 3};
    localparam bit[3:0] VEC_ERR  [NV] = '{4'b0000, 4'b1100, 4'b0101, 4'b0010,
                                         4'b1000, 4'b0111, 4'b1100, 4'b0000};
    localparam int      VEC_DIV  [NV] = '{2, 5, 5, 1, 3, 3, 6, 4};
    localparam string   REQ_OF   [4]  = '{"R1", "R2", "R3", "R4"};

    int exp_code [4];

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic nstep();
        @(negedge clk); #1;
    endtask

    task automatic do_write(input int code, input bit aid);
        wr_data = 32'hA5A5_00A4 | (32'(code) << 8) | 32'(aid);
        wr_en   = 1'b1;
        nstep();
        wr_en   = 1'b0;
    endtask

    task automatic wait_tick();
        do nstep(); while (!tick);
    endtask

    task automatic period(output int n);
        n = 0;
        do begin nstep(); n++; end while (!tick);
    endtask

    task automatic measure_new(output int n);
        wait_tick();
        wait_tick();
        period(n);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n, h;
        repeat (3) nstep();
        rst_n = 1'b1;
        nstep();

        // R12: reset state
        chk("R12 rd plus1", int'(rd[0]), 0);
        chk("R12 rd direct", int'(rd[1]), 32'h100);
        chk("R12 err", int'(err), 0);
        chk("R12 autoidle", int'(aen), 1);
        period(n);
        chk("R12 divisor 1", n, 1);
        exp_code = '{0, 1, 0, 0};

        // R1 R2 R3 R4 R5 R6 R7: encoding vectors across all four modes
        for (int i = 0; i < NV; i++) begin
            do_write(VEC_CODE[i], 1'b0);
            for (int m = 0; m < 4; m++) begin
                chk({REQ_OF[m], "/R6 err"}, int'(err[m]), int'(VEC_ERR[i][m]));
                if (!VEC_ERR[i][m]) exp_code[m] = VEC_CODE[i];
            end
            nstep();
            for (int m = 0; m < 4; m++)
                chk({REQ_OF[m], "/R5/R7 readback"}, int'(rd[m]), exp_code[m] << 8);
            measure_new(n);
            chk("R1/R7 period", n, VEC_DIV[i]);
        end

        // R8: write mid-period, old period completes
        do_write(5, 1'b0);
        measure_new(n);
        chk("R8 setup period", n, 6);
        wait_tick();
        nstep();
        nstep();
        do_write(1, 1'b0);
        period(n);
        chk("R8 old period kept", n + 3, 6);
        period(n);
        chk("R8 new period", n, 2);

        // R9: duty for N=5 and N=4
        do_write(4, 1'b0);
        measure_new(n);
        wait_tick();
        h = 0;
        repeat (5) begin if (dclk) h++; nstep(); end
        chk("R9 high steps N=5", h, 2);
        do_write(3, 1'b0);
        measure_new(n);
        wait_tick();
        h = 0;
        repeat (4) begin if (dclk) h++; nstep(); end
        chk("R9 high steps N=4", h, 2);

        // R11: inverted autoidle polarity
        do_write(1, 1'b1);
        chk("R11 autoidle off", int'(aen), 0);
        chk("R11 readback bit", int'(rd[0]), 32'h101);
        do_write(1, 1'b0);
        chk("R11 autoidle on", int'(aen), 1);

        // R7: error pulse lasts one cycle
        do_write(7, 1'b1);
        chk("R7 err high", int'(err[0]), 1);
        nstep();
        chk("R7 err one cycle", int'(err[0]), 0);
        chk("R7 reg kept", int'(rd[0]), 32'h100);

        // R13: gated steps, divisor 3 spans 6 cycles
        step_mode = 1;
        do_write(2, 1'b0);
        measure_new(n);
        chk("R13 gated period", n, 6);

        // R10: divisor 1 passes step_in through
        step_mode = 2;
        do_write(0, 1'b0);
        repeat (10) nstep();
        for (int k = 0; k < 9; k++) begin
            chk("R10 clk follows step", int'(dclk), int'(step_in));
            chk("R10 tick follows step", int'(tick), int'(step_in));
            nstep();
        end

        finish_run();
    end

endmodule